// File: doc/BRIEF.md
# Sparse Ling Prefix Adder

This block is a purely combinational unsigned adder. It returns the full sum of two operands together with the carry out of the top bit. It does not build the usual generate/propagate carry chain. Instead it forms Ling pseudo-carries. A pseudo-carry leaves out the propagate term of the bit it belongs to. The true carry is recovered later by ANDing the pseudo-carry with that bit's transmit signal (the OR of the two operand bits). Carry-in is fixed at zero.

The pseudo-carry tree has four levels with group sizes 4, 2, 4 and 2, which together span 64 bits. The first level computes 4-bit Ling groups straight from the operand bits. The later levels merge (pseudo-carry, transmit) pairs with the ordinary prefix rule.

In the default sparse form the tree keeps only the odd bit positions. The sum is built from 2-bit slices. Each slice is worked out for both possible values of its incoming pseudo-carry, and the tree output picks one of the two results. A build parameter selects a full tree instead, with a node at every bit. The full tree is used to cross-check the sparse form.

Top module: `ling_adder`

## Requirements
- R1: For every pair of operands, `{cout, sum}` equals the exact unsigned sum `a + b`, taken as a (WIDTH+1)-bit value.
- R2: When both operands are zero, `sum` is zero and `cout` is 0.
- R3: All ones plus one, in either operand order, gives `sum` equal to zero and `cout` equal to 1.
- R4: When the operands have no set bit in common, `sum` equals `a | b` and `cout` is 0. Examples are 0xAAAA...AAAA with 0x5555...5555, which gives all ones, and any value with a subset of its complement.
- R5: `cout` is 1 exactly when the true sum exceeds 2^WIDTH - 1. Equivalently, `cout` is 1 exactly when the wrapped `sum` is less than `a`.
- R6: The sparse build (`SPARSE` = 1) and the full build (`SPARSE` = 0) produce the same `sum` and `cout` for every operand pair.
- R7: For every k from 0 to WIDTH-1, the operand (2^k - 1) plus 1 gives `sum` equal to 2^k with `cout` 0. The carry born at bit 0 must therefore reach every bit position, whether that position is the start of a slice or the middle of one.
- R8: Adding zero is an identity. `a + 0` gives `a` and `0 + b` gives `b`, with `cout` 0 in both cases.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | WIDTH | First operand, unsigned |
| b | input | WIDTH | Second operand, unsigned |
| sum | output | WIDTH | Low WIDTH bits of a + b |
| cout | output | 1 | Carry out of bit WIDTH-1 |

## Verification
The bound checker looks at whatever operands are present and confirms four things: the sum against a reference addition, the carry-out against the wrapped-sum comparison, the zero-operand identity, and the no-shared-bits rule. It also checks the all-ones-plus-one wrap whenever that input occurs.

Only the bench scenarios can drive the carry-walk sweep over every bit position, so only they show that every pseudo-carry node and every slice select is reached. Only the bench can compare the sparse and full builds side by side, because it instantiates both of them.

// File: rtl/ling_pkg.sv
package ling_pkg;

    localparam int TREE_LEVELS = 4;

    // Group size of each tree level, lowest level first
    function automatic int tree_radix(input int lvl);
        case (lvl)
            0:       return 4;
            1:       return 2;
            2:       return 4;
            default: return 2;
        endcase
    endfunction

    // Bit distance between merged groups at a level (product of earlier radices)
    function automatic int tree_distance(input int lvl);
        int d;
        d = 1;
        for (int k = 0; k < lvl; k++) d = d * tree_radix(k);
        return d;
    endfunction

    typedef struct packed {
        logic h;   // pseudo-carry of the group
        logic t;   // transmit of the group, shifted down one bit
    } ling_pair_t;

    typedef struct packed {
        logic [1:0] hot;    // slice result for incoming pseudo-carry 1
        logic [1:0] cold;   // slice result for incoming pseudo-carry 0
    } ling_slice_t;

    // First-level 4-bit Ling group from bit generates and transmits.
    // gw[3] is bit i, gw[0] is bit i-3; tw[3] is bit i-1, tw[0] is bit i-4.
    function automatic ling_pair_t ling_seed4(input logic [3:0] gw, input logic [3:0] tw);
        ling_pair_t r;
        r.h = gw[3] | gw[2] | (tw[3] & gw[1]) | (tw[3] & tw[2] & gw[0]);
        r.t = &tw;
        return r;
    endfunction

    // Two sum bits for one slice, given the true carry entering it
    function automatic logic [1:0] ling_slice_sum(input logic [1:0] gg,
                                                  input logic [1:0] tt,
                                                  input logic       ci);
        logic [1:0] pp;
        logic       c1;
        pp = tt & ~gg;
        c1 = gg[0] | (tt[0] & ci);
        return {pp[1] ^ c1, pp[0] ^ ci};
    endfunction

endpackage

// File: rtl/ling_seed.sv
module ling_seed
    import ling_pkg::*;
#(
    parameter  int WIDTH = 64,
    parameter  int STEP  = 2,
    localparam int NODES = WIDTH / STEP
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    output logic [WIDTH-1:0] g,
    output logic [WIDTH-1:0] t,
    output logic [NODES-1:0] h_o,
    output logic [NODES-1:0] t_o
);

    // Zero padding below bit 0 so the lowest node's window stays in range
    localparam int PADG = 4 - STEP;
    localparam int PADT = 5 - STEP;

    logic [WIDTH+PADG-1:0]   gx;
    logic [WIDTH+PADT-2:0]   tx;

    assign g  = a & b;
    assign t  = a | b;
    assign gx = {g, {PADG{1'b0}}};
    assign tx = {t[WIDTH-2:0], {PADT{1'b0}}};

    for (genvar n = 0; n < NODES; n++) begin : g_node
        localparam int POS = n * STEP + STEP - 1;
        ling_pair_t pr;
        assign pr     = ling_seed4(gx[POS+PADG -: 4], tx[POS+PADT-1 -: 4]);
        assign h_o[n] = pr.h;
        assign t_o[n] = pr.t;
    end

endmodule

// File: rtl/ling_level.sv
module ling_level #(
    parameter int NODES = 32,
    parameter int RADIX = 2,
    parameter int OFF   = 2
) (
    input  logic [NODES-1:0] h_i,
    input  logic [NODES-1:0] t_i,
    output logic [NODES-1:0] h_o,
    output logic [NODES-1:0] t_o
);

    // Node n folds in the groups at n-OFF, n-2*OFF, ... (zero beyond bit 0)
    logic [NODES-1:0] ah [RADIX];
    logic [NODES-1:0] at [RADIX];

    assign ah[0] = h_i;
    assign at[0] = t_i;

    for (genvar k = 1; k < RADIX; k++) begin : g_fold
        assign ah[k] = ah[k-1] | (at[k-1] & (h_i << (k * OFF)));
        assign at[k] = at[k-1] & (t_i << (k * OFF));
    end

    assign h_o = ah[RADIX-1];
    assign t_o = at[RADIX-1];

endmodule

// File: rtl/ling_tree.sv
module ling_tree
    import ling_pkg::*;
#(
    parameter  int WIDTH = 64,
    parameter  int STEP  = 2,
    localparam int NODES = WIDTH / STEP
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    output logic [WIDTH-1:0] g,
    output logic [WIDTH-1:0] t,
    output logic [NODES-1:0] h_root
);

    localparam int LAST = TREE_LEVELS - 1;
    localparam int LR   = tree_radix(LAST);
    localparam int LOFF = tree_distance(LAST) / STEP;

    logic [NODES-1:0] hs [LAST];
    logic [NODES-1:0] ts [LAST];

    ling_seed #(
        .WIDTH(WIDTH),
        .STEP (STEP)
    ) seed_i (
        .a  (a),
        .b  (b),
        .g  (g),
        .t  (t),
        .h_o(hs[0]),
        .t_o(ts[0])
    );

    for (genvar l = 1; l < LAST; l++) begin : g_mid
        ling_level #(
            .NODES(NODES),
            .RADIX(tree_radix(l)),
            .OFF  (tree_distance(l) / STEP)
        ) level_i (
            .h_i(hs[l-1]),
            .t_i(ts[l-1]),
            .h_o(hs[l]),
            .t_o(ts[l])
        );
    end

    // Top level: only the pseudo-carry is needed, so no group transmit is formed
    logic [NODES-1:0] fh [LR];
    logic [NODES-1:0] ft [LR-1];

    assign fh[0] = hs[LAST-1];
    assign ft[0] = ts[LAST-1];

    for (genvar k = 1; k < LR; k++) begin : g_top
        assign fh[k] = fh[k-1] | (ft[k-1] & (hs[LAST-1] << (k * LOFF)));
        if (k < LR - 1) begin : g_tx
            assign ft[k] = ft[k-1] & (ts[LAST-1] << (k * LOFF));
        end
    end

    assign h_root = fh[LR-1];

endmodule

// File: rtl/ling_sum.sv
module ling_sum
    import ling_pkg::*;
#(
    parameter  int WIDTH = 64,
    parameter  int STEP  = 2,
    localparam int NODES = WIDTH / STEP
) (
    input  logic [WIDTH-1:0] g,
    input  logic [WIDTH-1:0] t,
    input  logic [NODES-1:0] h_root,
    output logic [WIDTH-1:0] sum,
    output logic             cout
);

    assign cout = t[WIDTH-1] & h_root[NODES-1];

    if (STEP == 1) begin : g_full
        logic [WIDTH-1:0] cin_v;
        assign cin_v = {t[WIDTH-2:0] & h_root[NODES-2:0], 1'b0};
        assign sum   = (t & ~g) ^ cin_v;
    end else begin : g_sparse
        for (genvar k = 0; k < NODES; k++) begin : g_slice
            if (k == 0) begin : g_low
                assign sum[1:0] = ling_slice_sum(g[1:0], t[1:0], 1'b0);
            end else begin : g_upper
                ling_slice_t sl;
                assign sl.hot  = ling_slice_sum(g[2*k+1 -: 2], t[2*k+1 -: 2], t[2*k-1]);
                assign sl.cold = ling_slice_sum(g[2*k+1 -: 2], t[2*k+1 -: 2], 1'b0);
                assign sum[2*k+1 -: 2] = h_root[k-1] ? sl.hot : sl.cold;
            end
        end
    end

endmodule

// File: rtl/ling_adder.sv
module ling_adder #(
    parameter int WIDTH  = 64,
    parameter bit SPARSE = 1'b1
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    output logic [WIDTH-1:0] sum,
    output logic             cout
);

    localparam int STEP  = SPARSE ? 2 : 1;
    localparam int NODES = WIDTH / STEP;

    logic [WIDTH-1:0] g_bits;
    logic [WIDTH-1:0] t_bits;
    logic [NODES-1:0] h_root;

    ling_tree #(
        .WIDTH(WIDTH),
        .STEP (STEP)
    ) tree_i (
        .a     (a),
        .b     (b),
        .g     (g_bits),
        .t     (t_bits),
        .h_root(h_root)
    );

    ling_sum #(
        .WIDTH(WIDTH),
        .STEP (STEP)
    ) sum_i (
        .g     (g_bits),
        .t     (t_bits),
        .h_root(h_root),
        .sum   (sum),
        .cout  (cout)
    );

endmodule

// File: rtl/ling_adder_chk.sv
module ling_adder_chk #(
    parameter int WIDTH = 64
) (
    input logic [WIDTH-1:0] a,
    input logic [WIDTH-1:0] b,
    input logic [WIDTH-1:0] sum,
    input logic             cout
);

    always_comb begin
        // R1
        sum_match_chk: assert ({cout, sum} == ({1'b0, a} + {1'b0, b}));
        // R5
        carry_out_chk: assert (cout == (sum < a));
        if (a == '0) begin
            // R8
            zero_operand_chk: assert (sum == b && !cout);
        end
        if ((a & b) == '0) begin
            // R4
            disjoint_chk: assert (sum == (a | b) && !cout);
        end
        if ((&a) && b == WIDTH'(1)) begin
            // R3
            all_ones_chk: assert (sum == '0 && cout);
        end
    end

endmodule

bind ling_adder ling_adder_chk #(.WIDTH(WIDTH)) chk_i (
    .a   (a),
    .b   (b),
    .sum (sum),
    .cout(cout)
);

// File: tb/ling_adder_tb_top.sv
module ling_adder_tb_top;

    localparam int CLK_PERIOD   = 10;
    localparam int W            = 64;
    localparam int RANDOM_COUNT = 1500;
    localparam int WATCHDOG     = 20000;

    logic         clk = 1'b0;
    logic [W-1:0] a   = '0;
    logic [W-1:0] b   = '0;
    logic [W-1:0] sum_s, sum_f;
    logic         cout_s, cout_f;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [W-1:0] a;
        logic [W-1:0] b;
        logic [W:0]   exp;
        string        tag;
    } item_t;

    item_t sb_q[$];

    always #(CLK_PERIOD / 2) clk = ~clk;

    ling_adder #(.WIDTH(W), .SPARSE(1'b1)) dut_i (
        .a(a), .b(b), .sum(sum_s), .cout(cout_s)
    );

    ling_adder #(.WIDTH(W), .SPARSE(1'b0)) dut_full_i (
        .a(a), .b(b), .sum(sum_f), .cout(cout_f)
    );

    // Driver: apply operands at a falling edge and queue the expected result
    task automatic drive(input logic [W-1:0] xa, input logic [W-1:0] xb, input string tag);
        item_t it;
        @(negedge clk);
        a      = xa;
        b      = xb;
        it.a   = xa;
        it.b   = xb;
        it.exp = {1'b0, xa} + {1'b0, xb};
        it.tag = tag;
        sb_q.push_back(it);
    endtask

    // Monitor: compare both builds half a cycle after the operands settle
    always @(posedge clk) begin
        item_t it;
        if (sb_q.size() > 0) begin
            it = sb_q.pop_front();
            checks++;
            if ({cout_s, sum_s} !== it.exp) begin
                fails++;
                $display("FAIL %s sparse a=%h b=%h actual=%h expected=%h",
                         it.tag, it.a, it.b, {cout_s, sum_s}, it.exp);
            end
            // R6: full build must agree with the same expected value
            checks++;
            if ({cout_f, sum_f} !== it.exp) begin
                fails++;
                $display("FAIL R6 full a=%h b=%h actual=%h expected=%h",
                         it.a, it.b, {cout_f, sum_f}, it.exp);
            end
        end
    end

    initial begin
        logic [W-1:0] x;
        // R2: both operands zero
        drive('0, '0, "R2");
        // R3: all ones plus one, both orders
        drive('1, W'(1), "R3");
        drive(W'(1), '1, "R3");
        // R4: no shared bits
        drive({(W/2){2'b10}}, {(W/2){2'b01}}, "R4");
        drive({(W/2){2'b01}}, {(W/2){2'b10}}, "R4");
        for (int i = 0; i < 32; i++) begin
            x = {$urandom, $urandom};
            drive(x, ~x & {$urandom, $urandom}, "R4");
        end
        // R5: carry-out boundaries
        drive('1, '1, "R5");
        drive({1'b1, {(W-1){1'b0}}}, {1'b1, {(W-1){1'b0}}}, "R5");
        drive('1, '0, "R5");
        drive({1'b0, {(W-1){1'b1}}}, {1'b1, {(W-1){1'b0}}}, "R5");
        drive({1'b1, {(W-1){1'b0}}}, {1'b1, {(W-2){1'b0}}, 1'b1}, "R5");
        // R7: carry from bit 0 walks to every position
        for (int k = 0; k < W; k++) begin
            drive((W'(1) << k) - W'(1), W'(1), "R7");
        end
        // R8: zero identity
        for (int i = 0; i < 16; i++) begin
            x = {$urandom, $urandom};
            drive(x, '0, "R8");
            drive('0, x, "R8");
        end
        // R1: random operands, including alternating-pattern sums
        drive({(W/2){2'b10}}, {(W/2){2'b10}}, "R1");
        drive({(W/2){2'b01}}, {(W/2){2'b11}}, "R1");
        for (int i = 0; i < RANDOM_COUNT; i++) begin
            drive({$urandom, $urandom}, {$urandom, $urandom}, "R1");
        end
        @(negedge clk);
        while (sb_q.size() > 0) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL R1 watchdog actual=%0d cycles expected=completion", WATCHDOG);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule